// File: doc/BRIEF.md
# Majority-Vote Dejustification Controller

This block sits on the receive side of a bit-interleaved multiplex, after the demultiplexer, and serves one tributary. For each received tributary bit it gets a slot code from the frame position logic: plain information, overhead, justification control, or the single justifiable slot. The control bits that carry the stuff indication are not adjacent in the frame. The block counts how many of them arrived set and takes a majority vote. That vote decides whether the justifiable slot in the same frame carries real data or a stuff bit.

The output is a gated write enable, with its data bit, for the tributary elastic store. Information bits are written. Overhead and control positions are never written. The justifiable slot is written only when the vote says it holds data, so a stuff bit is dropped. A per-frame decision flag and strobe are available, along with a wrapping count of dropped stuff bits. Because the indication is sent several times, one corrupted control bit cannot flip the outcome.

Top module: `dejust_ctrl`

## Requirements
- R1: After reset, wr_en, stuff_flag and dec_valid are 0 and stuff_count is 0.
- R2: An accepted bit with slot_type 2'b00 (information) gives wr_en=1 on the next cycle, with wr_data equal to that bit.
- R3: An accepted bit with slot_type 2'b01 (overhead: alignment word, service bits) or 2'b10 (justification control) gives wr_en=0 on the next cycle.
- R4: When the NCTRL-th control bit of a frame is accepted, dec_valid pulses high for one cycle on the next cycle. At the same time stuff_flag takes the value 1 if the number of set control bits is at least NCTRL/2+1 (2 of 3, or 3 of 5), and 0 otherwise. A single flipped control bit therefore never changes the decision. stuff_flag holds its value until the next decision.
- R5: An accepted bit with slot_type 2'b11 (justifiable) gives wr_en equal to the inverse of the current stuff_flag on the next cycle, with wr_data equal to that bit.
- R6: An accepted bit with frame_start=1 clears the vote tally and the control-bit position before that bit is processed, so no vote carries over from one frame to the next.
- R7: Control bits after the NCTRL-th one within a frame have no effect on the vote, stuff_flag or dec_valid.
- R8: stuff_count increases by one, modulo 2**CNT_W, one cycle after each justifiable slot that is dropped.
- R9: A cycle with bit_valid=0 gives wr_en=0 and dec_valid=0 on the next cycle, and it leaves the tally, stuff_flag and stuff_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive tributary clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | A tributary bit is present this cycle |
| bit_data | input | 1 | The tributary bit |
| slot_type | input | 2 | Slot code: 00 information, 01 overhead, 10 control, 11 justifiable |
| frame_start | input | 1 | Marks the first bit of a frame |
| wr_en | output | 1 | Write enable to the elastic store |
| wr_data | output | 1 | Data bit that goes with wr_en |
| stuff_flag | output | 1 | Latest majority decision, 1 means stuff |
| dec_valid | output | 1 | One-cycle strobe when a new decision is taken |
| stuff_count | output | CNT_W | Count of dropped stuff bits, wraps |

## Verification
The bench builds two instances that share one stimulus. One uses NCTRL=3 and the other NCTRL=5, and both use CNT_W=3. Every frame carries five control bits. The three-bit instance therefore sees its fourth and fifth control bits as surplus, which tests that they are ignored. The five-bit instance sees the full vote, so single-error patterns can be compared across both thresholds. The narrow counter wraps several times within the run.

// File: rtl/dejust_pkg.sv
package dejust_pkg;

   typedef enum logic [1:0] {
      SLOT_INFO = 2'b00,
      SLOT_OVH  = 2'b01,
      SLOT_CTRL = 2'b10,
      SLOT_JUST = 2'b11
   } slot_e;

endpackage

// File: rtl/dejust_vote.sv
// Tally of justification control bits within one frame.
module dejust_vote #(
   parameter int NCTRL  = 3,
   parameter int VOTE_W = $clog2(NCTRL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc,        // a bit is accepted this cycle
   input  logic clr,        // first bit of a frame
   input  logic is_ctrl,
   input  logic ctrl_val,
   output logic dec_load,
   output logic dec_val
);
   localparam int THRESH = NCTRL / 2 + 1;
   localparam logic [VOTE_W-1:0] LAST_POS = VOTE_W'(NCTRL - 1);
   localparam logic [VOTE_W-1:0] NPOS     = VOTE_W'(NCTRL);

   logic [VOTE_W-1:0] tally_q, seen_q;
   logic [VOTE_W-1:0] tally_b, seen_b;
   logic [VOTE_W:0]   sum_w;
   logic              take;

   always_comb begin
      tally_b  = clr ? '0 : tally_q;
      seen_b   = clr ? '0 : seen_q;
      take     = acc && is_ctrl && (seen_b < NPOS);
      sum_w    = {1'b0, tally_b} + {{VOTE_W{1'b0}}, ctrl_val};
      dec_load = take && (seen_b == LAST_POS);
      dec_val  = (sum_w >= (VOTE_W+1)'(THRESH));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally_q <= '0;
         seen_q  <= '0;
      end else if (acc) begin
         tally_q <= take ? sum_w[VOTE_W-1:0] : tally_b;
         seen_q  <= take ? seen_b + VOTE_W'(1) : seen_b;
      end
   end

endmodule

// File: rtl/dejust_gate.sv
// Write gating and decision register.
module dejust_gate
   import dejust_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  acc,
   input  slot_e slot,
   input  logic  din,
   input  logic  dec_load,
   input  logic  dec_val,
   output logic  wr_en,
   output logic  wr_data,
   output logic  stuff_flag,
   output logic  dec_valid,
   output logic  drop
);
   logic pass;

   always_comb begin
      pass = acc && ((slot == SLOT_INFO) || ((slot == SLOT_JUST) && !stuff_flag));
      drop = acc && (slot == SLOT_JUST) && stuff_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         wr_data    <= 1'b0;
         stuff_flag <= 1'b0;
         dec_valid  <= 1'b0;
      end else begin
         wr_en     <= pass;
         dec_valid <= dec_load;
         if (acc)      wr_data    <= din;
         if (dec_load) stuff_flag <= dec_val;
      end
   end

endmodule

// File: rtl/dejust_stuff_cnt.sv
module dejust_stuff_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/dejust_ctrl.sv
module dejust_ctrl
   import dejust_pkg::*;
#(
   parameter int NCTRL = 3,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_data,
   input  logic [1:0]       slot_type,
   input  logic             frame_start,
   output logic             wr_en,
   output logic             wr_data,
   output logic             stuff_flag,
   output logic             dec_valid,
   output logic [CNT_W-1:0] stuff_count
);
   localparam int VOTE_W = $clog2(NCTRL + 1);

   generate
      if (!(NCTRL == 3 || NCTRL == 5)) begin : g_bad_nctrl
         $error("NCTRL must be 3 or 5");
      end
      if (CNT_W < 1) begin : g_bad_cntw
         $error("CNT_W must be at least 1");
      end
   endgenerate

   slot_e slot;
   logic  dec_load, dec_val, drop;

   assign slot = slot_e'(slot_type);

   dejust_vote #(.NCTRL(NCTRL), .VOTE_W(VOTE_W)) u_vote (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (bit_valid),
      .clr      (frame_start),
      .is_ctrl  (slot == SLOT_CTRL),
      .ctrl_val (bit_data),
      .dec_load (dec_load),
      .dec_val  (dec_val)
   );

   dejust_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (bit_valid),
      .slot       (slot),
      .din        (bit_data),
      .dec_load   (dec_load),
      .dec_val    (dec_val),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .stuff_flag (stuff_flag),
      .dec_valid  (dec_valid),
      .drop       (drop)
   );

   dejust_stuff_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (drop),
      .count (stuff_count)
   );

endmodule

// File: rtl/dejust_ctrl_chk.sv
module dejust_ctrl_chk #(
   parameter int NCTRL = 3,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_valid,
   input logic             bit_data,
   input logic [1:0]       slot_type,
   input logic             wr_en,
   input logic             wr_data,
   input logic             stuff_flag,
   input logic             dec_valid,
   input logic [CNT_W-1:0] stuff_count
);
   localparam int NC = NCTRL;

   assert_info_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && slot_type == 2'b00) |=> (wr_en && wr_data == $past(bit_data)));

   assert_ovh_ctrl_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && (slot_type == 2'b01 || slot_type == 2'b10)) |=> !wr_en);

   assert_dec_after_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(bit_valid && slot_type == 2'b10));

   assert_flag_only_on_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> $stable(stuff_flag));

   assert_just_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && slot_type == 2'b11) |=> (wr_en == !$past(stuff_flag)));

   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && slot_type == 2'b11 && stuff_flag) |=>
         (stuff_count == $past(stuff_count) + CNT_W'(1)));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> (!wr_en && !dec_valid && $stable(stuff_count)));

   initial assert_nctrl_ok: assert (NC == 3 || NC == 5);

endmodule

bind dejust_ctrl dejust_ctrl_chk #(.NCTRL(NCTRL), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_valid   (bit_valid),
   .bit_data    (bit_data),
   .slot_type   (slot_type),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .stuff_flag  (stuff_flag),
   .dec_valid   (dec_valid),
   .stuff_count (stuff_count)
);

// File: tb/tb_dejust_ctrl.sv
`timescale 1ns/100ps
module tb_dejust_ctrl;
   localparam int CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_valid = 1'b0, bit_data = 1'b0, frame_start = 1'b0;
   logic [1:0] slot_type = 2'b00;

   logic wr_en3, wr_data3, flag3, dv3;
   logic wr_en5, wr_data5, flag5, dv5;
   logic [CW-1:0] cnt3, cnt5;

   always #2.5 clk = ~clk;

   dejust_ctrl #(.NCTRL(3), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
      .slot_type(slot_type), .frame_start(frame_start),
      .wr_en(wr_en3), .wr_data(wr_data3), .stuff_flag(flag3),
      .dec_valid(dv3), .stuff_count(cnt3));

   dejust_ctrl #(.NCTRL(5), .CNT_W(CW)) dut5 (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
      .slot_type(slot_type), .frame_start(frame_start),
      .wr_en(wr_en5), .wr_data(wr_data5), .stuff_flag(flag5),
      .dec_valid(dv5), .stuff_count(cnt5));

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model state, index 0 for NCTRL=3, 1 for NCTRL=5
   int votes [2];
   int seen  [2];
   int m_cnt [2];
   bit m_flag[2];
   bit e_wr  [2];
   bit e_dv  [2];
   bit e_d;
   string e_tag;
   bit have_exp = 1'b0;

   function automatic int nctrl_of(int i);
      return (i == 0) ? 3 : 5;
   endfunction

   function automatic bit majority(int v, int n);
      return v >= (n / 2 + 1);
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic check_outputs();
      for (int i = 0; i < 2; i++) begin
         logic w, d, f, v;
         logic [CW-1:0] c;
         w = (i == 0) ? wr_en3 : wr_en5;
         d = (i == 0) ? wr_data3 : wr_data5;
         f = (i == 0) ? flag3 : flag5;
         v = (i == 0) ? dv3 : dv5;
         c = (i == 0) ? cnt3 : cnt5;
         chk(w == e_wr[i], {e_tag, " wr_en"}, int'(w), int'(e_wr[i]));
         if (e_wr[i]) chk(d == e_d, {e_tag, " wr_data"}, int'(d), int'(e_d));
         chk(v == e_dv[i], "R4 dec_valid", int'(v), int'(e_dv[i]));
         chk(f == m_flag[i], "R4 R6 R7 stuff_flag", int'(f), int'(m_flag[i]));
         chk(c == CW'(m_cnt[i]), "R8 stuff_count", int'(c), m_cnt[i] % (1 << CW));
      end
   endtask

   task automatic step(bit v, bit fs, logic [1:0] st, bit d);
      @(negedge clk);
      if (have_exp) check_outputs();
      bit_valid = v; frame_start = fs; slot_type = st; bit_data = d;
      have_exp = 1'b1;
      e_d = d;
      if (!v) e_tag = "R9";
      else case (st)
         2'b00: e_tag = "R2";
         2'b11: e_tag = "R5";
         default: e_tag = "R3";
      endcase
      for (int i = 0; i < 2; i++) begin
         int n;
         n = nctrl_of(i);
         e_wr[i] = 1'b0;
         e_dv[i] = 1'b0;
         if (v) begin
            if (fs) begin votes[i] = 0; seen[i] = 0; end   // R6
            case (st)
               2'b00: e_wr[i] = 1'b1;
               2'b10: if (seen[i] < n) begin                // R7 beyond n
                  votes[i] += int'(d);
                  seen[i]++;
                  if (seen[i] == n) begin
                     e_dv[i] = 1'b1;
                     m_flag[i] = majority(votes[i], n);
                  end
               end
               2'b11: begin
                  e_wr[i] = !m_flag[i];
                  if (m_flag[i]) m_cnt[i] = (m_cnt[i] + 1) % (1 << CW);
               end
               default: ;
            endcase
         end
      end
   endtask

   task automatic slot(bit fs, logic [1:0] st, bit d);
      if (($urandom % 8) == 0) step(1'b0, 1'b0, 2'($urandom), 1'($urandom));
      step(1'b1, fs, st, d);
   endtask

   // frame: 2 overhead, 5 control bits spread among info bits, justifiable slot
   task automatic send_frame(logic [4:0] ctl);
      slot(1'b1, 2'b01, 1'($urandom));
      slot(1'b0, 2'b01, 1'($urandom));
      for (int k = 0; k < 5; k++) begin
         for (int j = 0; j < 3; j++) slot(1'b0, 2'b00, 1'($urandom));
         slot(1'b0, 2'b10, ctl[k]);
      end
      slot(1'b0, 2'b00, 1'($urandom));
      slot(1'b0, 2'b11, 1'($urandom));
      for (int j = 0; j < 3; j++) slot(1'b0, 2'b00, 1'($urandom));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 2; i++) begin
         votes[i] = 0; seen[i] = 0; m_cnt[i] = 0; m_flag[i] = 1'b0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!wr_en3 && !wr_en5, "R1 wr_en", int'(wr_en3 | wr_en5), 0);
      chk(!flag3 && !flag5, "R1 stuff_flag", int'(flag3 | flag5), 0);
      chk(!dv3 && !dv5, "R1 dec_valid", int'(dv3 | dv5), 0);
      chk(cnt3 == 0 && cnt5 == 0, "R1 stuff_count", int'(cnt3 | cnt5), 0);

      // directed: clean, single-error, surplus-control (R7) and threshold patterns
      send_frame(5'b00000);
      send_frame(5'b11111);
      send_frame(5'b11110);   // one error on each
      send_frame(5'b00001);   // one error: no stuff on both
      send_frame(5'b00011);   // 2 of 3 stuff, 2 of 5 no stuff
      send_frame(5'b11000);   // R7: NCTRL=3 sees no set bit
      send_frame(5'b11100);   // 1 of 3 no, 3 of 5 yes
      send_frame(5'b00111);
      send_frame(5'b00000);   // R6: previous tally must not carry
      for (int f = 0; f < 50; f++) send_frame(5'($urandom));
      step(1'b0, 1'b0, 2'b00, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule